// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a 45-bit physical address. It reads one 8-byte page-table entry for each of three table levels through a single-read memory port. A translation starts on a one-cycle start pulse while the walker is idle. The start pulse carries the virtual address and the physical address of the first-level table. The walker checks the unused upper address bits first. It then reads the three entries in order and waits for each response before it issues the next read. When the walk ends, it pulses done together with either the translated address or a fault code.

Pages are 8 KB. The low 13 address bits pass straight through. Each entry gives a 32-bit page number that either names the next table or, at the last level, the final page. The walker has no translation cache. Every request performs a full walk.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy_o, mem_req_o, done_o and fault_o are all low, and the walker accepts a start pulse.
- R2: On a successful walk, pa_o[12:0] equals va[12:0] and pa_o[44:13] equals the page number held in the third-level entry.
- R3: The read at level k goes to table base + 8 * index_k. The indices are: level 1 uses va[42:33], level 2 uses va[32:23], level 3 uses va[22:13]. The level-1 table base is the ptbr_i value captured with the start pulse.
- R4: An entry keeps its page number in bits [63:32]. For levels 1 and 2, the next table base is that page number followed by 13 zero bits.
- R5: A successful walk makes exactly three reads, for level 1, then level 2, then level 3. mem_req_o is a one-cycle pulse, and no new read is issued until the response (mem_rvalid_i) for the previous one has arrived.
- R6: An entry whose bit 0 is 0 ends the walk with done_o and fault_o high and fault_lvl_o set to the level (1, 2 or 3). No further read follows.
- R7: A virtual address whose bits [63:43] are not all equal to bit 42 faults with fault_lvl_o = 0. The fault appears in the cycle after the start pulse and no memory read is made.
- R8: A start pulse that arrives while busy_o is high is ignored, and the walk in progress finishes unchanged.
- R9: fault_o is only high together with done_o. When fault_o is high, pa_o is zero. When done_o is high and fault_o is low, fault_lvl_o is zero.
- R10: A mem_rvalid_i that arrives while no read is outstanding is ignored. It produces no done_o and does not start a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start_i | input | 1 | Start pulse for a translation, taken only while idle |
| va_i | input | 64 | Virtual address to translate |
| ptbr_i | input | 45 | Physical address of the first-level table |
| busy_o | output | 1 | A walk is in progress |
| mem_req_o | output | 1 | One-cycle read request for an entry |
| mem_addr_o | output | 45 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Entry data returned by memory |
| done_o | output | 1 | Translation finished, one-cycle pulse |
| fault_o | output | 1 | Translation failed, high with done_o |
| fault_lvl_o | output | 2 | Failing level; 0 means a bad upper address |
| pa_o | output | 45 | Translated physical address, valid with done_o |

## Verification
The assertions check the following on every cycle:
- read requests come as single-cycle pulses and never pile up;
- a bad upper address faults at once and makes no read;
- a stray response leaves the walker idle;
- the next table base is page aligned;
- the fault, level and address outputs agree with each other;
- the captured address holds while a start pulse arrives during a walk.

Only the bench's scenarios can show that the read addresses are right and that the final address is right. Those scenarios cover index values at both extremes, the largest page number with carry into the top address bits, faults at each level, and responses that arrive after different numbers of cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Walk geometry
  localparam int VA_W    = 64;
  localparam int PA_W    = 45;
  localparam int OFF_W   = 13;
  localparam int IDX_W   = 10;
  localparam int LEVELS  = 3;
  localparam int PTE_W   = 64;
  localparam int PPN_W   = PA_W - OFF_W;
  localparam int PTE_LG  = 3;
  // Derived
  localparam int SPARE_W  = VA_W - OFF_W - LEVELS * IDX_W;
  localparam int SIGN_BIT = OFF_W + LEVELS * IDX_W - 1;
  localparam int LVL_W    = $clog2(LEVELS + 1);
  localparam int SEL_N    = 1 << LVL_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} walk_st_e;

  function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base,
                                               input logic [IDX_W-1:0] idx);
    return base + (PA_W'(idx) << PTE_LG);
  endfunction

  function automatic logic [PPN_W-1:0] pte_ppn(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1 -: PPN_W];
  endfunction

  function automatic logic pte_ok(input logic [PTE_W-1:0] pte);
    return pte[0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  function automatic logic spare_bits_ok(input logic [VA_W-1:0] va);
    logic [SPARE_W:0] hi;
    hi = va[VA_W-1:SIGN_BIT];
    return (&hi) | ~(|hi);
  endfunction
endpackage

// File: rtl/ptw_va_check.sv
module ptw_va_check
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0] va_i,
  output logic            canon_ok_o
);
  assign canon_ok_o = spare_bits_ok(va_i);
endmodule

// File: rtl/ptw_pte_addr.sv
module ptw_pte_addr
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [PA_W-1:0]  base_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [IDX_W-1:0] idx_tbl [SEL_N];
  logic [IDX_W-1:0] idx_sel;

  // slot g holds the index for level g; level 1 is the highest field
  for (genvar g = 0; g < SEL_N; g++) begin : g_idx
    if (g >= 1 && g <= LEVELS) begin : g_used
      assign idx_tbl[g] = va_i[OFF_W + (LEVELS - g) * IDX_W +: IDX_W];
    end else begin : g_unused
      assign idx_tbl[g] = '0;
    end
  end

  assign idx_sel = idx_tbl[lvl_i];
  assign addr_o  = pte_addr(base_i, idx_sel);
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             canon_ok_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [PA_W-1:0]  ptbr_i,
  input  logic             rvalid_i,
  input  logic [PTE_W-1:0] rdata_i,
  output logic             busy_o,
  output logic             req_o,
  output logic [VA_W-1:0]  va_q_o,
  output logic [LVL_W-1:0] lvl_q_o,
  output logic [PA_W-1:0]  base_q_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [LVL_W-1:0] fault_lvl_o,
  output logic [PA_W-1:0]  pa_o
);
  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;
  logic             done_q, fault_q;
  logic [LVL_W-1:0] flvl_q;
  logic [PA_W-1:0]  pa_q;

  // named events
  logic accept_ev, bad_va_ev, rsp_ev, pte_bad_ev, last_lvl, walk_ok_ev, descend_ev;
  assign accept_ev  = (st_q == ST_IDLE) && start_i;
  assign bad_va_ev  = accept_ev && !canon_ok_i;
  assign rsp_ev     = (st_q == ST_WAIT) && rvalid_i;
  assign pte_bad_ev = rsp_ev && !pte_ok(rdata_i);
  assign last_lvl   = (lvl_q == LVL_W'(LEVELS));
  assign walk_ok_ev = rsp_ev && pte_ok(rdata_i) && last_lvl;
  assign descend_ev = rsp_ev && pte_ok(rdata_i) && !last_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      lvl_q   <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      pa_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      pa_q    <= '0;
      unique case (st_q)
        ST_IDLE: begin
          if (bad_va_ev) begin
            done_q  <= 1'b1;
            fault_q <= 1'b1;
          end else if (accept_ev) begin
            st_q   <= ST_ISSUE;
            va_q   <= va_i;
            base_q <= ptbr_i;
            lvl_q  <= LVL_W'(1);
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (pte_bad_ev) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            flvl_q  <= lvl_q;
          end else if (walk_ok_ev) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            pa_q   <= join_pa(pte_ppn(rdata_i), va_q[OFF_W-1:0]);
          end else if (descend_ev) begin
            st_q   <= ST_ISSUE;
            base_q <= {pte_ppn(rdata_i), {OFF_W{1'b0}}};
            lvl_q  <= lvl_q + LVL_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign req_o       = (st_q == ST_ISSUE);
  assign va_q_o      = va_q;
  assign lvl_q_o     = lvl_q;
  assign base_q_o    = base_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign fault_lvl_o = flvl_q;
  assign pa_o        = pa_q;

  a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);
  a_r5_no_req_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !rvalid_i) |=> !req_o);
  a_r4_base_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    descend_ev |=> (base_q[OFF_W-1:0] == '0) && req_o);
  a_r6_fault_level: assert property (@(posedge clk) disable iff (!rst_n)
    pte_bad_ev |=> fault_o && (fault_lvl_o == $past(lvl_q)) && !busy_o);
  a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(va_q));
  a_r10_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && rvalid_i && !start_i) |=> (!busy_o && !done_o));
  a_r9_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (done_o && pa_o == '0));
  a_r9_ok_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_o) |-> (fault_lvl_o == '0));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [PA_W-1:0]  ptbr_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [LVL_W-1:0] fault_lvl_o,
  output logic [PA_W-1:0]  pa_o
);
  logic             canon_ok;
  logic [VA_W-1:0]  va_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;

  ptw_va_check u_va_check (
    .va_i       (va_i),
    .canon_ok_o (canon_ok)
  );

  ptw_walk_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .canon_ok_i  (canon_ok),
    .va_i        (va_i),
    .ptbr_i      (ptbr_i),
    .rvalid_i    (mem_rvalid_i),
    .rdata_i     (mem_rdata_i),
    .busy_o      (busy_o),
    .req_o       (mem_req_o),
    .va_q_o      (va_q),
    .lvl_q_o     (lvl_q),
    .base_q_o    (base_q),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .fault_lvl_o (fault_lvl_o),
    .pa_o        (pa_o)
  );

  ptw_pte_addr u_addr (
    .va_i   (va_q),
    .lvl_i  (lvl_q),
    .base_i (base_q),
    .addr_o (mem_addr_o)
  );

  a_r7_bad_va_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !canon_ok) |=> (!mem_req_o && done_o && fault_o && fault_lvl_o == '0));
  a_r3_addr_stable_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> $stable(mem_addr_o));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_P = 10;
  localparam int WDOG  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] va_i = '0;
  logic [44:0] ptbr_i = '0;
  logic        busy_o, mem_req_o, done_o, fault_o;
  logic [44:0] mem_addr_o, pa_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic [1:0]  fault_lvl_o;

  always #(CLK_P/2) clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i), .ptbr_i(ptbr_i),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .fault_o(fault_o), .fault_lvl_o(fault_lvl_o), .pa_o(pa_o)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [63:0] pmem [logic [44:0]];
  int          lat = 1;
  int          rsp_timer = 0;
  logic [44:0] rsp_addr = '0;
  bit          stray = 0;

  function automatic logic [63:0] rd(input logic [44:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  always @(negedge clk) begin
    mem_rvalid_i = 1'b0;
    if (stray) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = 64'h0000_0777_0000_0001;
      stray = 0;
    end
    if (rsp_timer > 0) begin
      rsp_timer--;
      if (rsp_timer == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rd(rsp_addr);
      end
    end
    if (mem_req_o) begin
      rsp_addr  = mem_addr_o;
      rsp_timer = lat;
    end
  end

  // reference model
  logic [44:0] exp_addr[$];
  bit          exp_pending = 0;
  bit          exp_fault;
  int          exp_lvl;
  logic [44:0] exp_pa;
  bit          got_result = 0;
  bit          prev_req = 0;

  function automatic logic [63:0] mk_pte(input logic [31:0] ppn, input bit v);
    return {ppn, 31'h0, v};
  endfunction

  function automatic logic [63:0] mkva(input bit neg, input int i1, input int i2, input int i3, input int off);
    logic [63:0] v;
    v = (64'(i1 & 1023) << 33) | (64'(i2 & 1023) << 23) | (64'(i3 & 1023) << 13) | 64'(off & 8191);
    if (neg) v = v | (64'h1FFFFF << 43);
    return v;
  endfunction

  task automatic ref_walk(input logic [63:0] va, input logic [44:0] pt);
    logic signed [63:0] s;
    logic [44:0] base;
    logic [63:0] pte;
    exp_addr.delete();
    exp_fault = 0; exp_lvl = 0; exp_pa = '0;
    s = $signed(va);
    if (((s <<< 21) >>> 21) != s) begin
      exp_fault = 1;
      return;
    end
    base = pt;
    for (int l = 1; l <= 3; l++) begin
      logic [44:0] a;
      a = base + 45'((va >> (13 + 10 * (3 - l))) & 64'h3FF) * 45'd8;
      exp_addr.push_back(a);
      pte = rd(a);
      if (pte[0] == 1'b0) begin
        exp_fault = 1; exp_lvl = l;
        return;
      end
      base = 45'(pte >> 32) * 45'd8192;
      if (l == 3) exp_pa = base + 45'(va & 64'h1FFF);
    end
  endtask

  // every-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_o) begin
        chk(!prev_req, "R5 back-to-back request", 64'(mem_req_o), 64'd0);
        if (exp_addr.size() == 0)
          chk(0, "R5 unexpected read", 64'(mem_addr_o), 64'd0);
        else begin
          logic [44:0] ea;
          ea = exp_addr.pop_front();
          chk(mem_addr_o == ea, "R3/R4 entry address", 64'(mem_addr_o), 64'(ea));
        end
      end
      if (done_o) begin
        if (!exp_pending)
          chk(0, "R9/R10 unexpected done", 64'(done_o), 64'd0);
        else begin
          chk(fault_o == exp_fault, "R6/R7 fault flag", 64'(fault_o), 64'(exp_fault));
          chk(fault_lvl_o == 2'(exp_lvl), "R6/R7 fault level", 64'(fault_lvl_o), 64'(exp_lvl));
          chk(pa_o == exp_pa, "R2/R9 physical address", 64'(pa_o), 64'(exp_pa));
          chk(exp_addr.size() == 0, "R5/R6 read count", 64'(exp_addr.size()), 64'd0);
          exp_pending = 0;
          got_result = 1;
        end
      end
      prev_req = mem_req_o;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_walk(input logic [63:0] va, input logic [44:0] pt, input int latency,
                          input bit poke, input logic [63:0] poke_va);
    while (busy_o) @(negedge clk);
    lat = latency;
    ref_walk(va, pt);
    got_result = 0;
    exp_pending = 1;
    start_i = 1'b1; va_i = va; ptbr_i = pt;
    @(negedge clk);
    if (poke) begin
      va_i = poke_va; ptbr_i = ~pt;
      @(negedge clk);
      @(negedge clk);
    end
    start_i = 1'b0;
    while (!got_result) @(negedge clk);
  endtask

  localparam logic [44:0] PT = 45'h0000_0010_0000;
  logic [44:0] l2, l3, l2m, l3m;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 0, "R1 busy after reset", 64'(busy_o), 0);
    chk(mem_req_o == 0, "R1 req after reset", 64'(mem_req_o), 0);
    chk(done_o == 0 && fault_o == 0, "R1 done/fault after reset", 64'({done_o, fault_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // tables
    l2 = 45'h200 << 13;
    l3 = 45'h300 << 13;
    pmem[PT + 5 * 8]    = mk_pte(32'h200, 1);
    pmem[l2 + 10 * 8]   = mk_pte(32'h300, 1);
    pmem[l3 + 1023 * 8] = mk_pte(32'hDEAD_BEEF, 1);
    pmem[l3 + 0]        = mk_pte(32'h0001_2345, 1);
    pmem[l3 + 2 * 8]    = mk_pte(32'h0000_ABCD, 0);
    // extreme indices and largest page numbers
    l2m = 45'hFFFF_FFFF << 13;
    l3m = 45'h400 << 13;
    pmem[PT + 1023 * 8]   = mk_pte(32'hFFFF_FFFF, 1);
    pmem[l2m + 1023 * 8]  = mk_pte(32'h400, 1);
    pmem[l3m + 1023 * 8]  = mk_pte(32'hFFFF_FFFF, 1);

    // R2 R3 R4 R5: basic walk
    run_walk(mkva(0, 5, 10, 1023, 13'h1ABC), PT, 1, 0, 0);
    // R2: different offset and leaf, slower memory
    run_walk(mkva(0, 5, 10, 0, 13'h0001), PT, 3, 0, 0);
    // R3 R4: extreme indices, negative address with upper bits all ones, carry into top bits
    run_walk(mkva(1, 1023, 1023, 1023, 13'h1FFF), PT, 2, 0, 0);
    // R6: invalid entry at each level
    run_walk(mkva(0, 7, 0, 0, 0), PT, 1, 0, 0);
    run_walk(mkva(0, 5, 11, 0, 0), PT, 2, 0, 0);
    run_walk(mkva(0, 5, 10, 2, 13'h10), PT, 1, 0, 0);
    // R7: upper bits wrong
    run_walk(mkva(0, 5, 10, 0, 0) | (64'h1 << 50), PT, 1, 0, 0);
    run_walk(mkva(1, 5, 10, 0, 0), PT, 1, 0, 0);
    // R8: start pulse while busy is ignored
    run_walk(mkva(0, 5, 10, 1023, 13'h0042), PT, 4, 1, mkva(0, 7, 0, 0, 0));
    // R10: stray response while idle
    @(negedge clk);
    stray = 1;
    repeat (3) begin
      @(negedge clk);
      chk(done_o == 0, "R10 no done from stray rvalid", 64'(done_o), 0);
      chk(busy_o == 0, "R10 still idle after stray rvalid", 64'(busy_o), 0);
    end
    // R10: a walk after the stray response still works
    run_walk(mkva(0, 5, 10, 0, 13'h0F0F), PT, 1, 0, 0);
    repeat (4) @(negedge clk);
    chk(exp_addr.size() == 0, "R5 no leftover reads", 64'(exp_addr.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule